// File: doc/BRIEF.md
# SDRAM Bank Command Sequencer

This block sits between a simple request port and the command pins of an SDRAM device. Each request names a bank, a row and a column. It also says whether the access is a read or a write, and whether the bank should close once the access is done. The sequencer turns each request into the commands the device needs. A request to a closed bank gets an activate, then the column command. A request to the row already open in that bank goes straight to the column command. A request to a different row in an open bank gets a precharge, an activate and then the column command.

Each bank keeps its own record: whether it is closed, open with a known row, or recovering from a precharge. Each bank also has its own cycle timers for the activate-to-column gap, the activate-to-precharge gap and the precharge-to-activate gap. The block issues one command per clock and drives NOP on every other cycle. A new request can be accepted in the same cycle that the previous request's column command goes out. As a result, while one bank is still recovering, the next request may start on another bank.

The timing limits are cycle-count parameters: `T_RCD`, `T_RAS` and `T_RP`.

Top module: `sdram_cmd_seq`

## Requirements
- R1: While reset is held and right after it is released, the pins show NOP (chip select low, RAS/CAS/WE high), the bank and address outputs are zero, and `req_ready` is high.
- R2: Commands are encoded on {ras_n, cas_n, we_n} with chip select low: activate 011, read 101, write 100, precharge 010, NOP 111.
- R3: A request to a closed bank first produces an activate with the row on the address bus. The column command follows exactly `T_RCD` cycles later. In a column command, column bits 9..0 appear on A9..A0, column bit 10 appears on A11, A10 carries the close-after-access flag, and A12 is zero.
- R4: A request whose bank and row match the row open in that bank produces no activate. Its column command comes in the cycle right after the previous column command, provided the `T_RCD` gap has already passed.
- R5: A request to a different row of an open bank produces a precharge with A10 low, no earlier than `T_RAS` cycles after that bank's activate and no earlier than the cycle after the previous column command. The activate of the new row follows exactly `T_RP` cycles after the precharge.
- R6: A column command with the close flag set closes the bank. It is not issued before `T_RAS` cycles after the bank's activate. The next activate to that bank comes no sooner than `T_RP` cycles later.
- R7: While one bank is recovering from a precharge, a request to another closed bank gets its activate in the cycle right after the previous column command.
- R8: A request is taken only on a cycle where both `req_valid` and `req_ready` are high. `req_ready` stays low while the held request is waiting for a timing gap, and rises in the cycle its column command is chosen.
- R9: Banks keep their open rows independently. Activating a row in one bank does not close or change the open row of another bank, so a later request to the other bank's open row is still a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_autopre | input | 1 | Close the bank with the column command |
| req_bank | input | 2 | Bank select |
| req_row | input | 13 | Row address |
| req_col | input | 11 | Column address |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 13 | Multiplexed row/column address |

## Verification
Every bank in turn is driven through the same stream: a first access to a closed bank, a row hit, a row miss, a closing write, a re-open of the just-closed bank and a closing access to the next bank. Each cycle gap is compared with the gap worked out from the three timing parameters. The first access and the hit separate the `T_RCD` wait from a back-to-back column command. The miss shows whether `T_RAS` or the pipeline sets the precharge time. The re-open and the next-bank access separate a bank that must wait out `T_RP` from one that may start immediately. A last stream keeps two banks open at once, which shows that one bank's activate leaves the other bank's row open.

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq #(
  parameter int BANKS  = 4,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 11,
  parameter int AP_BIT = 10,
  parameter int T_RCD  = 3,
  parameter int T_RP   = 3,
  parameter int T_RAS  = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic                     req_autopre,
  input  logic [$clog2(BANKS)-1:0] req_bank,
  input  logic [ROW_W-1:0]         req_row,
  input  logic [COL_W-1:0]         req_col,
  output logic                     sd_cs_n,
  output logic                     sd_ras_n,
  output logic                     sd_cas_n,
  output logic                     sd_we_n,
  output logic [$clog2(BANKS)-1:0] sd_ba,
  output logic [ROW_W-1:0]         sd_addr
);
  localparam int BA_W  = $clog2(BANKS);
  localparam int TW    = $clog2(T_RCD + T_RP + T_RAS + 1);
  localparam int AGE_W = $clog2(T_RCD + T_RP + T_RAS + 2);

  typedef enum logic [1:0] {B_IDLE, B_OPEN, B_PRECH} bst_t;

  bst_t             st    [BANKS];
  logic [ROW_W-1:0] orow  [BANKS];
  logic [TW-1:0]    rcd_t [BANKS];
  logic [TW-1:0]    rp_t  [BANKS];
  logic [TW-1:0]    ras_t [BANKS];

  logic             p_vld, p_wr, p_ap;
  logic [BA_W-1:0]  p_ba;
  logic [ROW_W-1:0] p_row;
  logic [COL_W-1:0] p_col;

  logic open_b, hit, do_act, do_pre, do_col;
  logic [ROW_W-1:0] col_addr;

  assign open_b = (st[p_ba] == B_OPEN);
  assign hit    = open_b && (orow[p_ba] == p_row);

  always_comb begin
    do_act = 1'b0;
    do_pre = 1'b0;
    do_col = 1'b0;
    if (p_vld) begin
      if (hit)
        do_col = (rcd_t[p_ba] == '0) && (!p_ap || ras_t[p_ba] == '0);
      else if (open_b)
        do_pre = (ras_t[p_ba] == '0);
      else
        do_act = (rp_t[p_ba] == '0);
    end
  end

  assign req_ready = !p_vld || do_col;

  always_comb begin
    col_addr = '0;
    col_addr[AP_BIT-1:0]       = p_col[AP_BIT-1:0];
    col_addr[AP_BIT]           = p_ap;
    col_addr[COL_W:AP_BIT+1]   = p_col[COL_W-1:AP_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_vld <= 1'b0;
      p_wr  <= 1'b0;
      p_ap  <= 1'b0;
      p_ba  <= '0;
      p_row <= '0;
      p_col <= '0;
    end else if (req_valid && req_ready) begin
      p_vld <= 1'b1;
      p_wr  <= req_write;
      p_ap  <= req_autopre;
      p_ba  <= req_bank;
      p_row <= req_row;
      p_col <= req_col;
    end else if (do_col) begin
      p_vld <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < BANKS; i++) begin
      if (!rst_n) begin
        st[i]    <= B_IDLE;
        orow[i]  <= '0;
        rcd_t[i] <= '0;
        rp_t[i]  <= '0;
        ras_t[i] <= '0;
      end else begin
        rcd_t[i] <= (rcd_t[i] != '0) ? rcd_t[i] - 1'b1 : '0;
        rp_t[i]  <= (rp_t[i]  != '0) ? rp_t[i]  - 1'b1 : '0;
        ras_t[i] <= (ras_t[i] != '0) ? ras_t[i] - 1'b1 : '0;
        if (st[i] == B_PRECH && rp_t[i] == '0)
          st[i] <= B_IDLE;
        if (p_ba == BA_W'(i)) begin
          if (do_act) begin
            st[i]    <= B_OPEN;
            orow[i]  <= p_row;
            rcd_t[i] <= TW'(T_RCD - 1);
            ras_t[i] <= TW'(T_RAS - 1);
          end
          if (do_pre || (do_col && p_ap)) begin
            st[i]   <= B_PRECH;
            rp_t[i] <= TW'(T_RP - 1);
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} <= 4'b0111;
      sd_ba   <= '0;
      sd_addr <= '0;
    end else begin
      {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} <= 4'b0111;
      sd_ba   <= '0;
      sd_addr <= '0;
      if (do_act) begin
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} <= 4'b0011;
        sd_ba   <= p_ba;
        sd_addr <= p_row;
      end else if (do_col) begin
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} <= {3'b010, !p_wr};
        sd_ba   <= p_ba;
        sd_addr <= col_addr;
      end else if (do_pre) begin
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} <= 4'b0010;
        sd_ba   <= p_ba;
      end
    end
  end

  for (genvar g = 0; g < BANKS; g++) begin : g_watch
    logic [AGE_W-1:0] act_age, pre_age;
    logic obs_open, on_b, o_act, o_col, o_pre, o_close;
    assign on_b    = !sd_cs_n && (sd_ba == BA_W'(g));
    assign o_act   = on_b && {sd_ras_n, sd_cas_n, sd_we_n} == 3'b011;
    assign o_col   = on_b && !sd_cas_n && sd_ras_n;
    assign o_pre   = on_b && {sd_ras_n, sd_cas_n, sd_we_n} == 3'b010;
    assign o_close = o_pre || (o_col && sd_addr[AP_BIT]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        act_age  <= '1;
        pre_age  <= '1;
        obs_open <= 1'b0;
      end else begin
        act_age  <= o_act   ? AGE_W'(1) : (act_age == '1 ? act_age : act_age + 1'b1);
        pre_age  <= o_close ? AGE_W'(1) : (pre_age == '1 ? pre_age : pre_age + 1'b1);
        obs_open <= o_act ? 1'b1 : (o_close ? 1'b0 : obs_open);
      end
    end

    a_r3_rcd_gap: assert property (@(posedge clk) disable iff (!rst_n)
      o_col |-> act_age >= AGE_W'(T_RCD));
    a_r4_col_needs_open: assert property (@(posedge clk) disable iff (!rst_n)
      o_col |-> obs_open);
    a_r5_ras_gap: assert property (@(posedge clk) disable iff (!rst_n)
      o_close |-> act_age >= AGE_W'(T_RAS));
    a_r5_act_on_closed: assert property (@(posedge clk) disable iff (!rst_n)
      o_act |-> !obs_open);
    a_r6_rp_gap: assert property (@(posedge clk) disable iff (!rst_n)
      o_act |-> pre_age >= AGE_W'(T_RP));
  end

  a_r8_hold_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    (p_vld && !req_ready) |=> (p_vld && $stable(p_row) && $stable(p_ba)));
endmodule

// File: tb/test_sdram_cmd_seq.sv
module test_sdram_cmd_seq;
  localparam int RCD = 3, RP = 2, RAS = 7;
  localparam int C_ACT = 3, C_RD = 5, C_WR = 4, C_PRE = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, req_valid, req_ready, req_write, req_autopre;
  logic [1:0] req_bank, sd_ba;
  logic [12:0] req_row, sd_addr;
  logic [10:0] req_col;
  logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;

  sdram_cmd_seq #(.T_RCD(RCD), .T_RP(RP), .T_RAS(RAS)) i_sdram_cmd_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_autopre(req_autopre), .req_bank(req_bank),
    .req_row(req_row), .req_col(req_col), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr));

  int cyc = 0;
  int checks = 0, errors = 0;
  int lt[64], lc[64], lb[64], la[64];
  int ln = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk)
    if (rst_n && {sd_ras_n, sd_cas_n, sd_we_n} != 3'b111 && ln < 64) begin
      lt[ln] = cyc;
      lc[ln] = int'({sd_ras_n, sd_cas_n, sd_we_n});
      lb[ln] = int'(sd_ba);
      la[ln] = int'(sd_addr);
      ln = ln + 1;
    end

  task automatic chk(string r, int a, int e);
    checks++;
    if (a != e) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", r, a, e);
    end
  endtask

  task automatic clear_log();
    for (int i = 0; i < 64; i++) begin
      lt[i] = -1; lc[i] = -1; lb[i] = -1; la[i] = -1;
    end
    ln = 0;
  endtask

  function automatic int mapc(int c, int ap);
    return (((c >> 10) & 1) << 11) | (ap << 10) | (c & 1023);
  endfunction

  task automatic send(int w, int ap, int b, int row, int col, output int waits);
    req_write = w[0]; req_autopre = ap[0]; req_bank = b[1:0];
    req_row = row[12:0]; req_col = col[10:0]; req_valid = 1'b1;
    waits = 0;
    while (!req_ready) begin
      waits++;
      @(negedge clk);
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_cmd(string r, int i, int code, int b, int addr, int t);
    chk({"R2 type ", r}, lc[i], code);
    chk({r, " bank"}, lb[i], b);
    chk({r, " addr"}, la[i], addr);
    chk({r, " cycle"}, lt[i], t);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R8 actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int w, t0, t1, t2, t3, t4, t5, t6, t7, t8, t9, t10;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_autopre = 1'b0;
    req_bank = '0; req_row = '0; req_col = '0;
    clear_log();
    repeat (3) @(negedge clk);
    chk("R1 nop in reset", int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 7);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 nop after reset", int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 7);
    chk("R1 addr", int'(sd_addr), 0);
    chk("R1 bank", int'(sd_ba), 0);
    chk("R1 ready", int'(req_ready), 1);

    for (int b = 0; b < 4; b++) begin
      int bn, r0, r1, r2, r3, c1, c2, c3, c4, c5, c6;
      bn = (b + 1) % 4;
      r0 = 100 + b * 8; r1 = r0 + 1; r2 = r0 + 2; r3 = 200 + b;
      c1 = 1024 + b * 5; c2 = 1023 - b; c3 = 513 + b;
      c4 = 1536 + b; c5 = 7 * b; c6 = 2047 - b;
      clear_log();
      send(0, 0, b, r0, c1, w);
      send(1, 0, b, r0, c2, w);
      chk("R8 ready low while waiting", w, RCD);
      send(0, 0, b, r1, c3, w);
      send(1, 1, b, r1, c4, w);
      send(0, 1, b, r2, c5, w);
      send(0, 1, bn, r3, c6, w);
      idle(40);
      chk("R3 command count", ln, 11);
      t0 = lt[0];
      t1 = t0 + RCD;
      t2 = t1 + 1;
      t3 = (t2 + 1 > t0 + RAS) ? t2 + 1 : t0 + RAS;
      t4 = t3 + RP;
      t5 = t4 + RCD;
      t6 = (t5 + 1 > t4 + RAS) ? t5 + 1 : t4 + RAS;
      t7 = t6 + RP;
      t8 = t7 + ((RCD > RAS) ? RCD : RAS);
      t9 = t8 + 1;
      t10 = t9 + ((RCD > RAS) ? RCD : RAS);
      expect_cmd("R3 activate", 0, C_ACT, b, r0, t0);
      expect_cmd("R3 read", 1, C_RD, b, mapc(c1, 0), t1);
      expect_cmd("R4 hit write", 2, C_WR, b, mapc(c2, 0), t2);
      expect_cmd("R5 precharge", 3, C_PRE, b, 0, t3);
      expect_cmd("R5 activate", 4, C_ACT, b, r1, t4);
      expect_cmd("R5 read", 5, C_RD, b, mapc(c3, 0), t5);
      expect_cmd("R6 closing write", 6, C_WR, b, mapc(c4, 1), t6);
      expect_cmd("R6 reopen", 7, C_ACT, b, r2, t7);
      expect_cmd("R6 closing read", 8, C_RD, b, mapc(c5, 1), t8);
      expect_cmd("R7 other bank act", 9, C_ACT, bn, r3, t9);
      expect_cmd("R7 other bank read", 10, C_RD, bn, mapc(c6, 1), t10);
    end

    clear_log();
    send(0, 0, 0, 5, 3, w);
    send(0, 0, 1, 9, 4, w);
    send(0, 0, 0, 5, 6, w);
    send(0, 1, 1, 9, 8, w);
    send(0, 1, 0, 6, 10, w);
    idle(40);
    chk("R9 command count", ln, 9);
    chk("R2 R9 c0", lc[0], C_ACT); chk("R9 b0", lb[0], 0);
    chk("R2 R9 c1", lc[1], C_RD);  chk("R9 b1", lb[1], 0);
    chk("R2 R9 c2", lc[2], C_ACT); chk("R9 b2", lb[2], 1);
    chk("R2 R9 c3", lc[3], C_RD);  chk("R9 b3", lb[3], 1);
    chk("R2 R9 c4 hit", lc[4], C_RD); chk("R9 b4", lb[4], 0);
    chk("R2 R9 c5", lc[5], C_RD);  chk("R9 b5", lb[5], 1);
    chk("R2 R9 c6", lc[6], C_PRE); chk("R9 b6", lb[6], 0);
    chk("R2 R9 c7", lc[7], C_ACT); chk("R9 b7", lb[7], 0);
    chk("R2 R9 c8", lc[8], C_RD);  chk("R9 b8", lb[8], 0);
    chk("R9 hit follows directly", lt[4], lt[3] + 1);
    chk("R9 act bank1 while bank0 open", lt[2], lt[1] + 1);
    chk("R9 close flag on A10", la[5], mapc(8, 1));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule